// File: doc/BRIEF.md
# SPI Master Shift Engine

This block serialises one parallel word at a time onto the master-out line of an SPI bus and, on the same serial clock, gathers the bits returned on the master-in line into a received word. A producer offers words through a valid/ready handshake. The engine raises a one-cycle strobe with each received word. Chip selects, word buffering and register access belong to the surrounding logic.

The serial clock comes from a 16-bit half-period divider. Static configuration inputs set the following:
- the word width, from 2 to 16 bits, coded as width minus one;
- the clock polarity;
- the clock phase;
- the bit order;
- an internal loopback that routes the outgoing data into the receive side.

The engine shifts only while it is enabled, in master mode and out of soft reset. When a new word is already offered at the end of a word, it follows without an idle gap.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset, `sck` and `mosi` are 0, `rxDone` is 0, `rxData` is 0, and `txReady` is 0 while `cfgEnable` is 0.
- R2: While no word is in progress, `sck` rests at the `cfgCpol` level. `mosi` keeps the last bit it drove.
- R3: Every half-period of `sck` lasts `cfgDivider` clock cycles. The first `sck` edge of a word comes `cfgDivider` cycles after the clock edge on which the word is accepted.
- R4: A `cfgDivider` of 0 gives a half-period of 65536 cycles.
- R5: A `cfgDivider` from 1 to 6 is not a valid operating point. The engine runs such a value as 7.
- R6: A word has `cfgWidthM1`+1 bits and takes 2×(`cfgWidthM1`+1) half-periods. `rxData` bits at and above the word width read 0.
- R7: With `cfgMsbFirst`=1, bit `cfgWidthM1` goes out first and the first received bit lands in bit `cfgWidthM1`. With `cfgMsbFirst`=0, both start at bit 0.
- R8: A leading edge is the `sck` edge that leaves the `cfgCpol` level. With `cfgCpha`=0, the first bit is on `mosi` before the first leading edge, input is sampled on leading edges, and the next bit is driven on trailing edges. With `cfgCpha`=1, each bit is driven on a leading edge and sampled on the following trailing edge.
- R9: With `cfgLoop`=1, the receive side samples `mosi` instead of `miso`, and `miso` has no effect on `rxData`.
- R10: A word is accepted only when `txValid` and `txReady` are both 1. `txReady` is 0 unless `cfgEnable`=1, `cfgMaster`=1 and `cfgSoftReset`=0. Leaving that condition during a word abandons the word: no `rxDone` follows, and `sck` returns to `cfgCpol`.
- R11: `rxDone` is a one-cycle pulse in the cycle of the word's final `sck` edge. `rxData` holds the received word from that cycle until the next pulse.
- R12: When `txValid` is 1 at the final edge of a word, the next word is accepted in that same cycle. Consecutive `rxDone` pulses are then exactly 2×width×divider cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| cfgEnable | input | 1 | Engine enable |
| cfgMaster | input | 1 | Master mode select |
| cfgSoftReset | input | 1 | Soft reset; forces idle |
| cfgCpol | input | 1 | Serial clock idle level |
| cfgCpha | input | 1 | Serial clock phase |
| cfgMsbFirst | input | 1 | 1 = most significant bit first |
| cfgLoop | input | 1 | Internal loopback |
| cfgWidthM1 | input | 4 | Word width minus one |
| cfgDivider | input | 16 | Clocks per serial clock half-period (0 = 65536) |
| txValid | input | 1 | Transmit word offered |
| txData | input | 16 | Transmit word |
| txReady | output | 1 | Engine takes the word this cycle |
| rxData | output | 16 | Last received word |
| rxDone | output | 1 | Received word strobe |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench acts as a serial slave. It returns a word that differs from the transmitted one, so a swapped order, a wrong phase or a lost bit shows up on one side or the other. It sweeps every width from 2 to 16 bits over all four clock modes and both bit orders. This pins down the bit positions, the capture edges and the edge spacing.

Loopback runs use a slave word unlike the transmitted word, so any leak of `miso` into the received data is caught. Separate runs cover the following:
- a two-word burst, whose pulse spacing exposes an inserted idle gap;
- divider values 0 and 3, for the wrap to 65536 and the clamp to 7;
- master mode off;
- enable dropped in the middle of a word;
- soft reset.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int ENG_DATA_W = 16;
  localparam int ENG_IDX_W  = $clog2(ENG_DATA_W);

  // strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic                 load;     // word accepted this cycle
    logic                 tick;     // half-period ends, sck edge this cycle
    logic                 leading;  // the edge about to happen leaves the idle level
    logic                 wordEnd;  // final edge of the word
    logic                 abort;    // engine not allowed to run
    logic                 idle;     // no word in progress
    logic [ENG_IDX_W-1:0] bitIdx;   // bit number within the word
  } engStrobes_t;
endpackage

// File: rtl/spi_eng_ctrl.sv
module spi_eng_ctrl
  import spi_eng_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int MIN_DIV = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 active,
  input  logic                 txValid,
  input  logic [ENG_IDX_W-1:0] widthM1,
  input  logic [DIV_W-1:0]     divider,
  output logic                 txReady,
  output engStrobes_t          st
);
  localparam logic [DIV_W-1:0] MIN_LAST = DIV_W'(MIN_DIV - 1);

  logic                 busy;
  logic [DIV_W-1:0]     halfCnt;
  logic [ENG_IDX_W:0]   edgeIdx;
  logic [DIV_W-1:0]     lastCnt;
  logic                 tick;
  logic                 wordEnd;
  logic                 load;

  // divider 0 wraps to the full counter range; small values clamp
  always_comb begin
    if (divider != '0 && divider < DIV_W'(MIN_DIV)) lastCnt = MIN_LAST;
    else                                            lastCnt = divider - DIV_W'(1);
  end

  assign tick    = active && busy && (halfCnt == lastCnt);
  assign wordEnd = tick && (edgeIdx == {widthM1, 1'b1});
  assign txReady = active && (!busy || wordEnd);
  assign load    = txReady && txValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      halfCnt <= '0;
      edgeIdx <= '0;
    end else if (!active) begin
      busy    <= 1'b0;
      halfCnt <= '0;
      edgeIdx <= '0;
    end else if (load) begin
      busy    <= 1'b1;
      halfCnt <= '0;
      edgeIdx <= '0;
    end else if (wordEnd) begin
      busy    <= 1'b0;
      halfCnt <= '0;
    end else if (tick) begin
      halfCnt <= '0;
      edgeIdx <= edgeIdx + 1'b1;
    end else if (busy) begin
      halfCnt <= halfCnt + DIV_W'(1);
    end
  end

  always_comb begin
    st.load    = load;
    st.tick    = tick;
    st.leading = ~edgeIdx[0];
    st.wordEnd = wordEnd;
    st.abort   = !active;
    st.idle    = !busy;
    st.bitIdx  = edgeIdx[ENG_IDX_W:1];
  end
endmodule

// File: rtl/spi_eng_dp.sv
module spi_eng_dp
  import spi_eng_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  engStrobes_t           st,
  input  logic [ENG_DATA_W-1:0] txData,
  input  logic                  miso,
  input  logic                  cpol,
  input  logic                  cpha,
  input  logic                  msbFirst,
  input  logic                  loopEn,
  input  logic [ENG_IDX_W-1:0]  widthM1,
  output logic                  sck,
  output logic                  mosi,
  output logic [ENG_DATA_W-1:0] rxData,
  output logic                  rxDone
);
  logic [ENG_DATA_W-1:0] txWord;
  logic [ENG_DATA_W-1:0] rxWord;
  logic [ENG_DATA_W-1:0] rxMerged;
  logic [ENG_IDX_W-1:0]  curPos;
  logic [ENG_IDX_W-1:0]  nextPos;
  logic                  sampleNow;
  logic                  driveNow;
  logic                  driveBit;
  logic                  firstBit;
  logic                  inBit;

  function automatic logic [ENG_IDX_W-1:0] posOf(input logic [ENG_IDX_W-1:0] idx,
                                                 input logic msb,
                                                 input logic [ENG_IDX_W-1:0] top);
    return msb ? (top - idx) : idx;
  endfunction

  assign curPos    = posOf(st.bitIdx, msbFirst, widthM1);
  assign nextPos   = posOf(st.bitIdx + 1'b1, msbFirst, widthM1);
  assign sampleNow = st.tick && (st.leading ^ cpha);
  assign driveNow  = st.tick && (cpha ? st.leading : (!st.leading && (st.bitIdx != widthM1)));
  assign driveBit  = cpha ? txWord[curPos] : txWord[nextPos];
  assign firstBit  = msbFirst ? txData[widthM1] : txData[0];
  assign inBit     = loopEn ? mosi : miso;

  always_comb begin
    rxMerged = rxWord;
    if (sampleNow) rxMerged[curPos] = inBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sck    <= 1'b0;
      mosi   <= 1'b0;
      txWord <= '0;
      rxWord <= '0;
      rxData <= '0;
      rxDone <= 1'b0;
    end else begin
      rxDone <= st.wordEnd;
      if (st.wordEnd) rxData <= rxMerged;
      if (st.abort || (st.idle && !st.load)) begin
        sck <= cpol;
      end else if (st.load) begin
        sck    <= cpol;
        txWord <= txData;
        rxWord <= '0;
        if (!cpha) mosi <= firstBit;
      end else if (st.tick) begin
        sck    <= ~sck;
        rxWord <= rxMerged;
        if (driveNow) mosi <= driveBit;
      end
    end
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_eng_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int MIN_DIV = 7
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgEnable,
  input  logic                  cfgMaster,
  input  logic                  cfgSoftReset,
  input  logic                  cfgCpol,
  input  logic                  cfgCpha,
  input  logic                  cfgMsbFirst,
  input  logic                  cfgLoop,
  input  logic [ENG_IDX_W-1:0]  cfgWidthM1,
  input  logic [DIV_W-1:0]      cfgDivider,
  input  logic                  txValid,
  input  logic [ENG_DATA_W-1:0] txData,
  output logic                  txReady,
  output logic [ENG_DATA_W-1:0] rxData,
  output logic                  rxDone,
  output logic                  sck,
  output logic                  mosi,
  input  logic                  miso
);
  engStrobes_t strobes;
  logic        active;

  assign active = cfgEnable && cfgMaster && !cfgSoftReset;

  spi_eng_ctrl #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .active(active), .txValid(txValid),
    .widthM1(cfgWidthM1), .divider(cfgDivider), .txReady(txReady), .st(strobes)
  );

  spi_eng_dp u_dp (
    .clk(clk), .rstN(rstN), .st(strobes), .txData(txData), .miso(miso),
    .cpol(cfgCpol), .cpha(cfgCpha), .msbFirst(cfgMsbFirst), .loopEn(cfgLoop),
    .widthM1(cfgWidthM1), .sck(sck), .mosi(mosi), .rxData(rxData), .rxDone(rxDone)
  );
endmodule

// File: rtl/spi_shift_engine_chk.sv
module spi_shift_engine_chk (
  input logic clk,
  input logic rstN,
  input logic cfgEnable,
  input logic cfgMaster,
  input logic cfgSoftReset,
  input logic cfgCpol,
  input logic sck,
  input logic mosi,
  input logic rxDone
);
  logic inactive;
  assign inactive = !cfgEnable || !cfgMaster || cfgSoftReset;

  a_r2_idle_sck: assert property (@(posedge clk) disable iff (!rstN)
    inactive |=> (sck == $past(cfgCpol)));

  a_r2_mosi_hold: assert property (@(posedge clk) disable iff (!rstN)
    inactive |=> $stable(mosi));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> !rxDone);

  a_r10_no_done_inactive: assert property (@(posedge clk) disable iff (!rstN)
    inactive |=> !rxDone);

  a_r5_min_half_period: assert property (@(posedge clk)
    disable iff (!rstN || inactive)
    !$stable(sck) |=> $stable(sck));
endmodule

bind spi_shift_engine spi_shift_engine_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgMaster(cfgMaster),
  .cfgSoftReset(cfgSoftReset), .cfgCpol(cfgCpol), .sck(sck), .mosi(mosi),
  .rxDone(rxDone)
);

// File: tb/spi_shift_engine_bench.sv
`timescale 1ns/1ps
module spi_shift_engine_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN, cfgEnable, cfgMaster, cfgSoftReset, cfgCpol, cfgCpha;
  logic        cfgMsbFirst, cfgLoop, txValid, txReady, rxDone, sck, mosi, miso;
  logic [3:0]  cfgWidthM1;
  logic [15:0] cfgDivider, txData, rxData;

  spi_shift_engine u_spi_shift_engine (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgMaster(cfgMaster),
    .cfgSoftReset(cfgSoftReset), .cfgCpol(cfgCpol), .cfgCpha(cfgCpha),
    .cfgMsbFirst(cfgMsbFirst), .cfgLoop(cfgLoop), .cfgWidthM1(cfgWidthM1),
    .cfgDivider(cfgDivider), .txValid(txValid), .txData(txData), .txReady(txReady),
    .rxData(rxData), .rxDone(rxDone), .sck(sck), .mosi(mosi), .miso(miso)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // slave model and monitor state
  bit          monOn = 0, gapOn = 0, edgeNow, lead;
  logic        prevSck = 0, prevDone = 0;
  int          lastEdge = 0, acceptMark = 0, refCyc, curDiv = 7, badGap = 0;
  int          gapErr = 0, edgeCnt = 0, doneCnt = 0, acceptCnt = 0;
  int          doneNoEdge = 0, doneWide = 0;
  int          doneCyc [4];
  int          acceptCyc [4];
  logic [3:0]  slaveBit = 0, p;
  logic [1:0]  slaveIdx = 0;
  logic [15:0] slaveAcc = 0;
  logic [15:0] slaveTx [4];
  logic [15:0] capTx [4];
  logic [15:0] gotRx [4];
  logic [3:0]  misoPos;

  assign misoPos = cfgMsbFirst ? (cfgWidthM1 - slaveBit) : slaveBit;
  assign miso    = slaveTx[slaveIdx][misoPos];

  always @(negedge clk) begin
    #1;
    edgeNow = (sck !== prevSck);
    if (monOn) begin
      if (edgeNow) begin
        edgeCnt++;
        refCyc = (acceptMark > lastEdge && acceptMark < cyc) ? acceptMark : lastEdge;
        if (gapOn && (cyc - refCyc) != curDiv) begin gapErr++; badGap = cyc - refCyc; end
        lastEdge = cyc;
        lead = (sck != cfgCpol);
        p = cfgMsbFirst ? (cfgWidthM1 - slaveBit) : slaveBit;
        if (lead != cfgCpha) slaveAcc[p] = mosi;
        if (!lead) begin
          if (slaveBit == cfgWidthM1) begin
            capTx[slaveIdx] = slaveAcc;
            slaveAcc = '0;
            slaveIdx = slaveIdx + 1'b1;
            slaveBit = '0;
          end else begin
            slaveBit = slaveBit + 1'b1;
          end
        end
      end
      if (txValid && txReady) begin
        acceptMark = cyc + 1;
        acceptCyc[acceptCnt % 4] = cyc + 1;
        acceptCnt++;
      end
      if (rxDone) begin
        gotRx[doneCnt % 4] = rxData;
        doneCyc[doneCnt % 4] = cyc;
        doneCnt++;
        if (!edgeNow) doneNoEdge++;
        if (prevDone) doneWide++;
      end
    end
    prevSck  = sck;
    prevDone = rxDone;
  end

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 190000 && !finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=190000", cyc);
      report();
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic slaveClear(input logic [15:0] s0, input logic [15:0] s1);
    slaveBit = 0; slaveIdx = 0; slaveAcc = 0;
    gapErr = 0; edgeCnt = 0; doneCnt = 0; acceptCnt = 0;
    doneNoEdge = 0; doneWide = 0; badGap = 0;
    slaveTx[0] = s0; slaveTx[1] = s1; slaveTx[2] = 0; slaveTx[3] = 0;
  endtask

  task automatic configure(input int wm1, input int mode, input int msb,
                           input int lp, input int div);
    @(negedge clk);
    monOn = 0; gapOn = 0;
    cfgWidthM1 = 4'(wm1); cfgCpol = mode[1]; cfgCpha = mode[0];
    cfgMsbFirst = msb[0]; cfgLoop = lp[0]; cfgDivider = 16'(div);
    cfgEnable = 1; cfgMaster = 1; cfgSoftReset = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic runWords(input int n, input int wm1, input int mode, input int msb,
                          input int lp, input int div, input int expDiv,
                          input logic [15:0] w0, input logic [15:0] w1,
                          input logic [15:0] s0, input logic [15:0] s1);
    logic [15:0] mask, expTx, expRx, lastW;
    configure(wm1, mode, msb, lp, div);
    slaveClear(s0, s1);
    curDiv = expDiv; monOn = 1; gapOn = 1;
    for (int k = 0; k < n; k++) begin
      txValid = 1; txData = (k == 0) ? w0 : w1;
      #1;
      while (!txReady) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    txValid = 0;
    for (int i = 0; i < 4000 && doneCnt < n; i++) @(negedge clk);
    @(negedge clk); #2;
    mask = 16'((32'd1 << (wm1 + 1)) - 1);
    chk(doneCnt == n, "R11 done count", doneCnt, n);
    for (int k = 0; k < n; k++) begin
      expTx = ((k == 0) ? w0 : w1) & mask;
      expRx = lp[0] ? expTx : (((k == 0) ? s0 : s1) & mask);
      chk(capTx[k] == expTx, "R7/R8 bits seen on mosi", capTx[k], expTx);
      chk(rxData == rxData && gotRx[k] == expRx,
          lp[0] ? "R9 loopback word" : "R6/R7/R8 received word", gotRx[k], expRx);
    end
    chk(gapErr == 0, "R3/R5 half-period", badGap, expDiv);
    chk(doneCyc[n-1] - acceptCyc[0] == n * 2 * (wm1 + 1) * expDiv,
        "R6/R12 word duration", doneCyc[n-1] - acceptCyc[0], n * 2 * (wm1 + 1) * expDiv);
    chk(doneWide == 0 && doneNoEdge == 0, "R11 pulse on final edge",
        doneWide + doneNoEdge, 0);
    chk(sck == cfgCpol, "R2 sck idle level", sck, cfgCpol);
    lastW = (n == 1) ? w0 : w1;
    chk(mosi == (msb[0] ? lastW[0] : lastW[wm1]), "R2 mosi holds last bit",
        mosi, msb[0] ? lastW[0] : lastW[wm1]);
  endtask

  initial begin
    rstN = 0; cfgEnable = 0; cfgMaster = 0; cfgSoftReset = 0; cfgCpol = 0;
    cfgCpha = 0; cfgMsbFirst = 1; cfgLoop = 0; cfgWidthM1 = 7; cfgDivider = 7;
    txValid = 0; txData = 0;
    for (int i = 0; i < 4; i++) begin slaveTx[i] = 0; capTx[i] = 0; gotRx[i] = 0; end
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk); #2;
    // R1 reset state
    chk(sck == 0 && mosi == 0, "R1 sck/mosi after reset", {sck, mosi}, 0);
    chk(rxDone == 0 && rxData == 0, "R1 rx outputs after reset", rxData, 0);
    chk(txReady == 0, "R1 not ready while disabled", txReady, 0);

    // sweep: all widths, modes and orders
    for (int wm1 = 1; wm1 < 16; wm1++)
      for (int mode = 0; mode < 4; mode++)
        for (int msb = 0; msb < 2; msb++) begin
          logic [15:0] w, s;
          w = 16'(32'h9E37 * (wm1 * 8 + mode * 2 + msb + 1));
          s = ~w ^ 16'h5A5A;
          runWords(1, wm1, mode, msb, 0, 7, 7, w, 0, s, 0);
        end

    // R9 loopback with a foreign slave word
    for (int mode = 0; mode < 4; mode++)
      runWords(1, 15, mode, mode % 2, 1, 8, 8, 16'hC3A1 + 16'(mode), 0, 16'h0F0F, 0);

    // R12 back-to-back words
    runWords(2, 7, 1, 1, 0, 9, 9, 16'h00B4, 16'h005D, 16'h0071, 16'h00E2);
    runWords(2, 11, 2, 0, 0, 7, 7, 16'h0A5C, 16'h03E1, 16'h0F00, 16'h0555);

    // R5 divider below minimum clamps to 7
    runWords(1, 3, 0, 1, 0, 3, 7, 16'h000B, 0, 16'h0006, 0);

    // R10 master mode off: nothing accepted
    configure(7, 0, 1, 0, 7);
    cfgMaster = 0;
    slaveClear(0, 0); monOn = 1;
    txValid = 1; txData = 16'h00AA;
    #1;
    chk(txReady == 0, "R10 ready low without master mode", txReady, 0);
    repeat (40) @(negedge clk);
    #2;
    chk(acceptCnt == 0 && edgeCnt == 0, "R10 no shifting without master mode",
        acceptCnt + edgeCnt, 0);
    txValid = 0;

    // R10 enable dropped mid-word
    configure(7, 2, 1, 0, 7);
    slaveClear(0, 0); monOn = 1;
    txValid = 1; txData = 16'h0033;
    @(negedge clk);
    txValid = 0;
    repeat (30) @(negedge clk);
    cfgEnable = 0;
    repeat (200) @(negedge clk);
    #2;
    chk(doneCnt == 0, "R10 abandoned word gives no done", doneCnt, 0);
    chk(sck == 1'b1, "R10 sck back at idle level after abort", sck, 1);

    // R4 divider zero is 65536, then R10 soft reset aborts
    configure(7, 0, 1, 0, 0);
    slaveClear(0, 0);
    curDiv = 65536; monOn = 1; gapOn = 1;
    txValid = 1; txData = 16'h0081;
    @(negedge clk);
    txValid = 0;
    for (int i = 0; i < 70000 && edgeCnt == 0; i++) @(negedge clk);
    #2;
    chk(edgeCnt == 1 && gapErr == 0, "R4 divider zero half-period", badGap, 65536);
    gapOn = 0;
    @(negedge clk);
    cfgSoftReset = 1;
    #1;
    chk(txReady == 0, "R10 ready low in soft reset", txReady, 0);
    repeat (10) @(negedge clk);
    #2;
    chk(sck == 0 && doneCnt == 0, "R10 soft reset returns to idle", {sck, 8'(doneCnt)}, 0);
    cfgSoftReset = 0;
    monOn = 0;

    report();
  end
endmodule